// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out where an instruction's operand lives. Each cycle it may take a 3-bit mode code, the values read from the register file for a base and an index register, and the instruction's constant field. From these it produces either an operand value (register and immediate forms) or a memory address (every other form). For auto-modifying pointer forms it also produces the new pointer value and a strobe, so the register file can write that value back.

A single width select applies to everything the unit generates. Cleared, every address and every written-back pointer is cut to 24 bits. Set, they are cut to 31 bits. All arithmetic is done at 32 bits and masked afterwards. Results are registered and appear one clock after the request strobe. In every cycle with no request, all strobes and data outputs are zero.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode 000 (register): `opnd` equals `base_val`, while `ea`, `ea_vld` and `wb_en` are all 0.
- R2: Mode 001 (immediate): `opnd` equals `disp`, while `ea`, `ea_vld` and `wb_en` are all 0.
- R3: Mode 010 (absolute): `ea` equals the masked `disp`, `ea_vld` is 1 and `wb_en` is 0.
- R4: Mode 011 (indirect): `ea` equals the masked `base_val`, `ea_vld` is 1 and `wb_en` is 0.
- R5: Mode 100 (pre-decrement): the new pointer is `base_val` minus the step. `ea` and `wb_val` both equal the masked new pointer, and `ea_vld` and `wb_en` are 1.
- R6: Mode 101 (post-increment): `ea` equals the masked `base_val`. `wb_val` equals the masked `base_val` plus the step, and `ea_vld` and `wb_en` are 1.
- R7: The step is the parameter FIXED_STEP (default 4) when `step_sel` is 0, and the zero-extended 8-bit `step_amt` when `step_sel` is 1.
- R8: Mode 110 (indexed): `ea` equals the masked value of `base_val` + (`index_en` ? `index_val` : 0) + `disp`, summed modulo 2^32. `ea_vld` is 1 and `wb_en` is 0.
- R9: With `wide` = 0, bits 31:24 of `ea` and of `wb_val` are 0. With `wide` = 1, bit 31 of each is 0. Any carry past the active width is lost.
- R10: Mode 111 is illegal: `err` is 1, and `ea_vld`, `wb_en`, `ea`, `opnd` and `wb_val` are 0.
- R11: Outputs appear on the clock after `in_vld` is high, and `out_vld` then is 1. After a cycle with `in_vld` low, every output is 0, so `wb_en` lasts exactly one cycle per request.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| mode | input | 3 | Addressing form code |
| wide | input | 1 | 0: 24-bit addresses, 1: 31-bit addresses |
| base_val | input | 32 | Base / pointer register value |
| index_val | input | 32 | Index register value |
| index_en | input | 1 | Include index in indexed form |
| disp | input | 32 | Instruction constant (immediate, absolute address or displacement) |
| step_sel | input | 1 | 0: fixed step, 1: step from `step_amt` |
| step_amt | input | 8 | Instruction-given step |
| out_vld | output | 1 | Result valid |
| ea_vld | output | 1 | `ea` holds a memory address |
| ea | output | 32 | Effective address |
| opnd | output | 32 | Operand for register / immediate forms |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_val | output | 32 | Updated pointer value |
| err | output | 1 | Illegal mode flag |

## Verification
In one cycle, the pointer update and the width mask can act on the same value. This happens when an increment carries past bit 23 or bit 30, or when a decrement borrows below zero. The bench provokes this with pointers at 0x00FFFFFC and 0x7FFFFFFF and with a zero pointer in pre-decrement, in both widths. It judges the result by checking that `wb_val` and `ea` come out wrapped inside the active width, with no bit above it set. Back-to-back pointer requests are also run. They check that each write-back strobe belongs to its own request and does not linger into an idle cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int EA_XLEN = 32;

    typedef enum logic [2:0] {
        M_REG   = 3'b000,
        M_IMM   = 3'b001,
        M_ABS   = 3'b010,
        M_IND   = 3'b011,
        M_PREDC = 3'b100,
        M_POSTI = 3'b101,
        M_BIX   = 3'b110,
        M_BAD   = 3'b111
    } ea_mode_e;

    typedef struct packed {
        logic                 vld;
        logic                 ea_vld;
        logic                 wb_en;
        logic                 err;
        logic [EA_XLEN-1:0]   ea;
        logic [EA_XLEN-1:0]   opnd;
        logic [EA_XLEN-1:0]   wb_val;
    } ea_out_t;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
    parameter int XLEN       = 32,
    parameter int STEP_W     = 8,
    parameter int FIXED_STEP = 4
) (
    input  logic              step_sel,
    input  logic [STEP_W-1:0] step_amt,
    output logic [XLEN-1:0]   step
);
    localparam int PAD_W = XLEN - STEP_W;
    localparam logic [XLEN-1:0] FIXED_V = XLEN'(FIXED_STEP);

    always_comb begin
        step = step_sel ? {{PAD_W{1'b0}}, step_amt} : FIXED_V;
    end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int XLEN     = 32,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    input  logic            wide,
    output logic [XLEN-1:0] y
);
    localparam logic [XLEN-1:0] NARROW_M = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [XLEN-1:0] WIDE_M   = {{(XLEN-WIDE_W){1'b0}}, {WIDE_W{1'b1}}};

    logic [XLEN-1:0] raw;

    always_comb begin
        raw = a + b + c;
        y   = raw & (wide ? WIDE_M : NARROW_M);
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
    parameter int XLEN       = ea_pkg::EA_XLEN,
    parameter int STEP_W     = 8,
    parameter int FIXED_STEP = 4,
    parameter int NARROW_W   = 24,
    parameter int WIDE_W     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [2:0]        mode,
    input  logic              wide,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   index_val,
    input  logic              index_en,
    input  logic [XLEN-1:0]   disp,
    input  logic              step_sel,
    input  logic [STEP_W-1:0] step_amt,
    output logic              out_vld,
    output logic              ea_vld,
    output logic [XLEN-1:0]   ea,
    output logic [XLEN-1:0]   opnd,
    output logic              wb_en,
    output logic [XLEN-1:0]   wb_val,
    output logic              err
);
    import ea_pkg::*;

    localparam logic [XLEN-1:0] ZERO = '0;

    logic [XLEN-1:0] step, step_neg, idx_term;
    logic [XLEN-1:0] abs_a, ptr_a, pre_a, post_a, bix_a;
    ea_out_t res_d, res_q;
    ea_mode_e mode_e;

    assign mode_e   = ea_mode_e'(mode);
    assign step_neg = ~step + 1'b1;
    assign idx_term = index_en ? index_val : ZERO;

    ea_step #(.XLEN(XLEN), .STEP_W(STEP_W), .FIXED_STEP(FIXED_STEP)) u_step (
        .step_sel(step_sel), .step_amt(step_amt), .step(step)
    );

    ea_sum #(.XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_abs (
        .a(disp), .b(ZERO), .c(ZERO), .wide(wide), .y(abs_a)
    );
    ea_sum #(.XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_ptr (
        .a(base_val), .b(ZERO), .c(ZERO), .wide(wide), .y(ptr_a)
    );
    ea_sum #(.XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_pre (
        .a(base_val), .b(step_neg), .c(ZERO), .wide(wide), .y(pre_a)
    );
    ea_sum #(.XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_post (
        .a(base_val), .b(step), .c(ZERO), .wide(wide), .y(post_a)
    );
    ea_sum #(.XLEN(XLEN), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_bix (
        .a(base_val), .b(idx_term), .c(disp), .wide(wide), .y(bix_a)
    );

    always_comb begin
        res_d = '0;
        if (in_vld) begin
            res_d.vld = 1'b1;
            unique case (mode_e)
                M_REG:   res_d.opnd = base_val;
                M_IMM:   res_d.opnd = disp;
                M_ABS:   begin res_d.ea_vld = 1'b1; res_d.ea = abs_a; end
                M_IND:   begin res_d.ea_vld = 1'b1; res_d.ea = ptr_a; end
                M_PREDC: begin
                    res_d.ea_vld = 1'b1;
                    res_d.ea     = pre_a;
                    res_d.wb_en  = 1'b1;
                    res_d.wb_val = pre_a;
                end
                M_POSTI: begin
                    res_d.ea_vld = 1'b1;
                    res_d.ea     = ptr_a;
                    res_d.wb_en  = 1'b1;
                    res_d.wb_val = post_a;
                end
                M_BIX:   begin res_d.ea_vld = 1'b1; res_d.ea = bix_a; end
                default: res_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld = res_q.vld;
    assign ea_vld  = res_q.ea_vld;
    assign ea      = res_q.ea;
    assign opnd    = res_q.opnd;
    assign wb_en   = res_q.wb_en;
    assign wb_val  = res_q.wb_val;
    assign err     = res_q.err;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [2:0]  mode,
    input logic        wide,
    input logic        out_vld,
    input logic        ea_vld,
    input logic [31:0] ea,
    input logic        wb_en,
    input logic [31:0] wb_val,
    input logic        err
);
    // R11
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !ea_vld && !wb_en && !err));
    // R10
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 3'b111) |=> (err && !ea_vld && !wb_en));
    // R10
    no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode != 3'b111) |=> !err);
    // R9
    narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !wide) |=> (ea[31:24] == 8'h00 && wb_val[31:24] == 8'h00));
    // R9
    wide_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && wide) |=> (!ea[31] && !wb_val[31]));
    // R5
    ptr_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mode == 3'b100 || mode == 3'b101)) |=> (wb_en && ea_vld));
    // R1
    reg_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mode == 3'b000 || mode == 3'b001)) |=> (!ea_vld && !wb_en));
    // R8
    bix_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mode == 3'b010 || mode == 3'b011 || mode == 3'b110)) |=> (ea_vld && !wb_en));
endmodule

bind ea_gen_unit ea_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .wide(wide),
    .out_vld(out_vld), .ea_vld(ea_vld), .ea(ea), .wb_en(wb_en),
    .wb_val(wb_val), .err(err)
);

// File: tb/sim_ea_gen_unit.sv
`timescale 1ns/1ps
module sim_ea_gen_unit;
    typedef struct {
        logic        vld, ea_vld, wb_en, err;
        logic [31:0] ea, opnd, wb_val;
        string       tag;
    } exp_t;

    logic clk = 0, rst_n = 0, in_vld = 0, wide = 0, index_en = 0, step_sel = 0;
    logic [2:0]  mode = 0;
    logic [31:0] base_val = 0, index_val = 0, disp = 0;
    logic [7:0]  step_amt = 0;
    logic out_vld, ea_vld, wb_en, err;
    logic [31:0] ea, opnd, wb_val;

    int checks = 0, fails = 0;
    bit running = 0, done = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ea_gen_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .wide(wide),
        .base_val(base_val), .index_val(index_val), .index_en(index_en),
        .disp(disp), .step_sel(step_sel), .step_amt(step_amt),
        .out_vld(out_vld), .ea_vld(ea_vld), .ea(ea), .opnd(opnd),
        .wb_en(wb_en), .wb_val(wb_val), .err(err)
    );

    function automatic logic [31:0] msk(input logic w, input logic [31:0] v);
        return v & (w ? 32'h7FFF_FFFF : 32'h00FF_FFFF);
    endfunction

    function automatic void compare(input exp_t e);
        checks++;
        if (out_vld !== e.vld || ea_vld !== e.ea_vld || wb_en !== e.wb_en ||
            err !== e.err || ea !== e.ea || opnd !== e.opnd || wb_val !== e.wb_val) begin
            fails++;
            $display("FAIL %s: got vld=%b eav=%b wb=%b err=%b ea=%h op=%h wbv=%h exp vld=%b eav=%b wb=%b err=%b ea=%h op=%h wbv=%h",
                e.tag, out_vld, ea_vld, wb_en, err, ea, opnd, wb_val,
                e.vld, e.ea_vld, e.wb_en, e.err, e.ea, e.opnd, e.wb_val);
        end
    endfunction

    task automatic req(input string tag, input logic [2:0] m, input logic w,
                       input logic [31:0] b, input logic [31:0] ix, input logic ixe,
                       input logic [31:0] d, input logic ss, input logic [7:0] sa);
        exp_t e;
        logic [31:0] st;
        @(negedge clk);
        in_vld = 1; mode = m; wide = w; base_val = b; index_val = ix;
        index_en = ixe; disp = d; step_sel = ss; step_amt = sa;
        st = ss ? {24'h0, sa} : 32'd4;
        e = '{vld:1, ea_vld:0, wb_en:0, err:0, ea:0, opnd:0, wb_val:0, tag:tag};
        case (m)
            3'd0: e.opnd = b;
            3'd1: e.opnd = d;
            3'd2: begin e.ea_vld = 1; e.ea = msk(w, d); end
            3'd3: begin e.ea_vld = 1; e.ea = msk(w, b); end
            3'd4: begin e.ea_vld = 1; e.wb_en = 1; e.ea = msk(w, b - st); e.wb_val = e.ea; end
            3'd5: begin e.ea_vld = 1; e.wb_en = 1; e.ea = msk(w, b); e.wb_val = msk(w, b + st); end
            3'd6: begin e.ea_vld = 1; e.ea = msk(w, b + (ixe ? ix : 32'h0) + d); end
            default: e.err = 1;
        endcase
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 0; mode = 3'd5; base_val = 32'hFFFF_FFFF;
        e = '{vld:0, ea_vld:0, wb_en:0, err:0, ea:0, opnd:0, wb_val:0, tag:tag};
        q.push_back(e);
    endtask

    // monitor: sample 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (running && q.size() > 0) compare(q.pop_front());
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_t r;
        // R12: outputs zero while in reset, even with request held high
        in_vld = 1; mode = 3'd5; base_val = 32'h1234;
        repeat (3) @(negedge clk);
        r = '{vld:0, ea_vld:0, wb_en:0, err:0, ea:0, opnd:0, wb_val:0, tag:"R12 reset"};
        compare(r);
        in_vld = 0;
        @(negedge clk); rst_n = 1;
        running = 1;

        req("R1 register", 3'd0, 0, 32'hDEAD_BEEF, 0, 0, 32'h55, 0, 0);
        req("R2 immediate", 3'd1, 0, 32'h1111, 0, 0, 32'hFEDC_BA98, 0, 0);
        req("R3 absolute narrow", 3'd2, 0, 0, 0, 0, 32'hAB12_3456, 0, 0);
        req("R3 absolute wide", 3'd2, 1, 0, 0, 0, 32'hAB12_3456, 0, 0);
        req("R4 indirect", 3'd3, 1, 32'hF000_1000, 0, 0, 0, 0, 0);
        req("R5 predec fixed", 3'd4, 0, 32'h0000_1000, 0, 0, 0, 0, 0);
        req("R5 R7 predec step from zero", 3'd4, 0, 32'h0, 0, 0, 0, 1, 8'd8);
        req("R6 R9 postinc narrow wrap", 3'd5, 0, 32'h00FF_FFFC, 0, 0, 0, 0, 0);
        idle("R11 idle after write-back");
        req("R6 R9 postinc wide wrap", 3'd5, 1, 32'h7FFF_FFFF, 0, 0, 0, 1, 8'd1);
        req("R7 postinc step 200", 3'd5, 1, 32'h100, 0, 0, 0, 1, 8'd200);
        req("R8 indexed with index", 3'd6, 1, 32'h1000, 32'h20, 1, 32'h3, 0, 0);
        req("R8 indexed index off", 3'd6, 1, 32'h1000, 32'h20, 0, 32'h3, 0, 0);
        req("R8 R9 indexed carry", 3'd6, 0, 32'h00FF_FFF0, 32'h10, 1, 32'h5, 0, 0);
        req("R10 illegal", 3'd7, 1, 32'h1234, 0, 0, 32'h99, 0, 0);
        idle("R11 idle after error");
        req("R4 indirect narrow", 3'd3, 0, 32'hFFAB_CDEF, 0, 0, 0, 0, 0);
        idle("R11 idle");
        idle("R11 idle 2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule